// File: doc/BRIEF.md
# PPM Bit Slicer and Sequencer

This block sits behind the preamble detector of a 1090 MHz pulse-position receiver. Magnitude samples arrive one per clock at 12.5 samples per 1 µs bit. Each bit is sliced by comparing the energy in its early half-bit with the energy in its late half-bit. Processing is strictly sample by sample, and no message is buffered.

A four-state sequencer governs the work. It waits for a preamble indication, then waits for the first-bit mark. It then slices 88 information bits, then 24 checksum bits. When slicing starts, it pulses a clear for the downstream checksum logic. Each decided bit leaves with a strobe and a flag that tells information bits from checksum bits. The end of a 112-bit message is signalled by a one-cycle done pulse. A synchronous abort returns the sequencer to its idle search state from anywhere.

Top module: `ppm_slicer_seq`

## Requirements
- R1: After reset the sequencer is in the search state, and every output is 0.
- R2: In the search state, `sync_i` moves the sequencer to the wait state, and `t0_i` has no effect. While waiting with no `t0_i`, neither phase flag rises.
- R3: `t0_i` in the wait state starts slicing. In the next cycle `data_phase_o` is 1 and `ck_clr_o` pulses for exactly that one cycle. `mag_i` of that same next cycle is sample 0 of bit 0.
- R4: Bits with an even index (counting from 0) last 12 samples, and bits with an odd index last 13. `bit_vld_o` is 1 for one cycle, in the cycle after the last sample of each bit.
- R5: The early sum covers samples 0..5 of a bit, and the late sum covers its final 6 samples. Sample 6 of a 13-sample bit has no effect on the decision.
- R6: `bit_o` is 1 when the early sum is strictly larger than the late sum, and 0 otherwise. Equal sums give 0.
- R7: Bits 0..87 arrive with `bit_is_ck_o`=0 while `data_phase_o`=1. Bits 88..111 arrive with `bit_is_ck_o`=1 while `ck_phase_o`=1. The two phase flags are never 1 together.
- R8: `msg_done_o` is 1 for one cycle, together with the strobe of bit 111. In that cycle both phase flags are already 0, and the sequencer is back in search.
- R9: `abort_i` forces the search state on the next edge. A bit whose last sample arrives in the abort cycle is not emitted, and a `t0_i` after the abort is ignored.
- R10: Sums are exact at full-scale input. Early samples all 4095 against late samples all 4094 give 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock, one sample per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mag_i | input | MAG_W | Sample magnitude, unsigned |
| sync_i | input | 1 | Preamble found |
| t0_i | input | 1 | Next sample is the first bit sample |
| abort_i | input | 1 | Synchronous return to search |
| bit_o | output | 1 | Decided bit |
| bit_vld_o | output | 1 | Strobe for bit_o |
| bit_is_ck_o | output | 1 | Strobed bit is a checksum bit |
| data_phase_o | output | 1 | Slicing information bits |
| ck_phase_o | output | 1 | Slicing checksum bits |
| msg_done_o | output | 1 | Last bit of the message strobed |
| ck_clr_o | output | 1 | Clear pulse for the checksum logic |

## Verification
The embedded assertions check the sequencing rules on every cycle. These are: the entry into slicing with its clear pulse, the exclusive phase flags, the forced return to search after an abort, the done pulse falling on a checksum-bit strobe with both phases low, and the range of the in-bit sample counter. Some behaviour only the bench scenarios can show: the 12/13 alternation of bit lengths across a whole message, the exclusion of the middle sample, the tie rule, the full-scale sums, and a bit that is dropped when an abort coincides with its last sample. The bench does this by comparing every output, on every cycle, with a schedule that it derives from the samples it drives.

// File: rtl/ppm_pkg.sv
package ppm_pkg;
  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_WAIT   = 2'd1,
    ST_BITS   = 2'd2,
    ST_CKSUM  = 2'd3
  } seq_st_e;
endpackage

// File: rtl/ppm_bit_timer.sv
module ppm_bit_timer #(
  parameter int SMP_EVEN = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic first_o,
  output logic in_a_o,
  output logic in_b_o,
  output logic last_o
);
  localparam int HALF  = SMP_EVEN / 2;
  localparam int CNT_W = $clog2(SMP_EVEN + 2);

  logic [CNT_W-1:0] cnt_q, len;
  logic             odd_q;

  // odd-index bits take one extra sample so the period averages 12.5
  assign len     = odd_q ? CNT_W'(SMP_EVEN + 1) : CNT_W'(SMP_EVEN);
  assign first_o = (cnt_q == '0);
  assign in_a_o  = (cnt_q < CNT_W'(HALF));
  assign in_b_o  = (cnt_q >= len - CNT_W'(HALF));
  assign last_o  = run_i && (cnt_q == len - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      odd_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      odd_q <= 1'b0;
    end else if (last_o) begin
      cnt_q <= '0;
      odd_q <= ~odd_q;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // R4
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(SMP_EVEN));

  // R4
  bit_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && last_o) |=> (cnt_q == '0) && (odd_q != $past(odd_q) || !$past(run_i)));
endmodule

// File: rtl/ppm_half_acc.sv
module ppm_half_acc #(
  parameter int MAG_W = 12,
  parameter int HALF  = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [MAG_W-1:0] mag_i,
  input  logic             first_i,
  input  logic             in_a_i,
  input  logic             in_b_i,
  input  logic             take_i,
  input  logic             is_ck_i,
  input  logic             last_bit_i,
  output logic             bit_o,
  output logic             vld_o,
  output logic             ck_o,
  output logic             done_o
);
  localparam int SUM_W = MAG_W + $clog2(HALF + 1);

  logic [SUM_W-1:0] mag_x, a_q, b_q, b_fin;

  assign mag_x = {{(SUM_W - MAG_W){1'b0}}, mag_i};
  assign b_fin = b_q + mag_x;  // last sample always belongs to the late half

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q    <= '0;
      b_q    <= '0;
      bit_o  <= 1'b0;
      vld_o  <= 1'b0;
      ck_o   <= 1'b0;
      done_o <= 1'b0;
    end else begin
      a_q    <= first_i ? mag_x : (in_a_i ? a_q + mag_x : a_q);
      b_q    <= first_i ? '0    : (in_b_i ? b_fin : b_q);
      vld_o  <= take_i;
      ck_o   <= take_i && is_ck_i;
      done_o <= take_i && last_bit_i;
      if (take_i) bit_o <= (a_q > b_fin);  // tie resolves to 0
    end
  end

  // R8
  done_on_ck_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (vld_o && ck_o));
endmodule

// File: rtl/ppm_seq_ctrl.sv
module ppm_seq_ctrl
  import ppm_pkg::*;
#(
  parameter int N_DATA = 88,
  parameter int N_CK   = 24
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    sync_i,
  input  logic    t0_i,
  input  logic    abort_i,
  input  logic    bit_end_i,
  output seq_st_e state_o,
  output logic    run_o,
  output logic    clr_o,
  output logic    last_bit_o
);
  localparam int N_TOT  = N_DATA + N_CK;
  localparam int BCNT_W = $clog2(N_TOT);

  seq_st_e           st_q, st_d;
  logic [BCNT_W-1:0] bcnt_q;
  logic              start;

  assign start      = (st_q == ST_WAIT) && t0_i && !abort_i;
  assign run_o      = (st_q == ST_BITS) || (st_q == ST_CKSUM);
  assign last_bit_o = (bcnt_q == BCNT_W'(N_TOT - 1));
  assign state_o    = st_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_SEARCH: if (sync_i) st_d = ST_WAIT;
      ST_WAIT:   if (t0_i) st_d = ST_BITS;
      ST_BITS:   if (bit_end_i && bcnt_q == BCNT_W'(N_DATA - 1)) st_d = ST_CKSUM;
      ST_CKSUM:  if (bit_end_i && last_bit_o) st_d = ST_SEARCH;
      default:   st_d = ST_SEARCH;
    endcase
    if (abort_i) st_d = ST_SEARCH;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_SEARCH;
      bcnt_q <= '0;
      clr_o  <= 1'b0;
    end else begin
      st_q  <= st_d;
      clr_o <= start;
      if (start) bcnt_q <= '0;
      else if (run_o && bit_end_i && !last_bit_o) bcnt_q <= bcnt_q + BCNT_W'(1);
    end
  end

  // R3
  t0_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT && t0_i && !abort_i) |=> (st_q == ST_BITS && clr_o));

  // R2
  search_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SEARCH) |=> (st_q == ST_SEARCH || st_q == ST_WAIT));

  // R9
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (st_q == ST_SEARCH && !clr_o));

  // R7
  ck_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CKSUM) |-> (bcnt_q >= BCNT_W'(N_DATA)));
endmodule

// File: rtl/ppm_slicer_seq.sv
module ppm_slicer_seq
  import ppm_pkg::*;
#(
  parameter int MAG_W    = 12,
  parameter int N_DATA   = 88,
  parameter int N_CK     = 24,
  parameter int SMP_EVEN = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [MAG_W-1:0] mag_i,
  input  logic             sync_i,
  input  logic             t0_i,
  input  logic             abort_i,
  output logic             bit_o,
  output logic             bit_vld_o,
  output logic             bit_is_ck_o,
  output logic             data_phase_o,
  output logic             ck_phase_o,
  output logic             msg_done_o,
  output logic             ck_clr_o
);
  localparam int HALF = SMP_EVEN / 2;

  seq_st_e st;
  logic    run, last_bit, first, in_a, in_b, last_smp, bit_end, take;

  assign bit_end      = run && last_smp;
  assign take         = bit_end && !abort_i;
  assign data_phase_o = (st == ST_BITS);
  assign ck_phase_o   = (st == ST_CKSUM);

  ppm_seq_ctrl #(.N_DATA(N_DATA), .N_CK(N_CK)) u_ctrl (
    .clk_i, .rst_ni, .sync_i, .t0_i, .abort_i,
    .bit_end_i  (bit_end),
    .state_o    (st),
    .run_o      (run),
    .clr_o      (ck_clr_o),
    .last_bit_o (last_bit)
  );

  ppm_bit_timer #(.SMP_EVEN(SMP_EVEN)) u_timer (
    .clk_i, .rst_ni,
    .run_i   (run),
    .first_o (first),
    .in_a_o  (in_a),
    .in_b_o  (in_b),
    .last_o  (last_smp)
  );

  ppm_half_acc #(.MAG_W(MAG_W), .HALF(HALF)) u_acc (
    .clk_i, .rst_ni, .mag_i,
    .first_i    (first),
    .in_a_i     (in_a),
    .in_b_i     (in_b),
    .take_i     (take),
    .is_ck_i    (ck_phase_o),
    .last_bit_i (last_bit),
    .bit_o      (bit_o),
    .vld_o      (bit_vld_o),
    .ck_o       (bit_is_ck_o),
    .done_o     (msg_done_o)
  );

  // R7
  phase_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({data_phase_o, ck_phase_o}));

  // R8
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_done_o |-> (!data_phase_o && !ck_phase_o));

  // R3
  clr_in_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ck_clr_o |-> (data_phase_o && !bit_vld_o));
endmodule

// File: tb/tb_ppm_slicer_seq.sv
module tb_ppm_slicer_seq;
  localparam int MW = 12, ND = 88, NC = 24, NT = 112, SE = 12, HF = 6;

  logic          clk = 1'b0, rst_ni = 1'b0;
  logic [MW-1:0] mag = '0;
  logic          sync = 1'b0, t0 = 1'b0, abort = 1'b0;
  logic          bit_o, bit_vld_o, bit_is_ck_o, data_phase_o, ck_phase_o, msg_done_o, ck_clr_o;

  ppm_slicer_seq #(.MAG_W(MW), .N_DATA(ND), .N_CK(NC), .SMP_EVEN(SE)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .mag_i(mag), .sync_i(sync), .t0_i(t0), .abort_i(abort),
    .bit_o(bit_o), .bit_vld_o(bit_vld_o), .bit_is_ck_o(bit_is_ck_o),
    .data_phase_o(data_phase_o), .ck_phase_o(ck_phase_o),
    .msg_done_o(msg_done_o), .ck_clr_o(ck_clr_o));

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  bit mon_en = 1'b0, finished = 1'b0;
  string ctx = "R6";
  int unsigned seed = 32'h1234_5678;

  bit e_vld[int], e_bit[int], e_ck[int], e_done[int], e_dp[int], e_cp[int], e_clr[int];

  task automatic chk(input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cyc=%0d actual=%0b expected=%0b", what, cyc, act, exp);
    end
  endtask

  function automatic int rnd(input int n);
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) % n);
  endfunction

  // per-cycle comparison against the schedule
  always @(negedge clk) if (mon_en && !finished) begin
    bit ev;
    ev = e_vld.exists(cyc) ? e_vld[cyc] : 1'b0;
    chk(bit_vld_o, ev, "R4 bit_vld_o");
    if (ev && bit_vld_o) begin
      chk(bit_o, e_bit[cyc], {"bit_o ", ctx});
      chk(bit_is_ck_o, e_ck[cyc], "R7 bit_is_ck_o");
    end
    chk(msg_done_o, e_done.exists(cyc) ? e_done[cyc] : 1'b0, "R8 msg_done_o");
    chk(data_phase_o, e_dp.exists(cyc) ? e_dp[cyc] : 1'b0, "R7 data_phase_o");
    chk(ck_phase_o, e_cp.exists(cyc) ? e_cp[cyc] : 1'b0, "R7 ck_phase_o");
    chk(ck_clr_o, e_clr.exists(cyc) ? e_clr[cyc] : 1'b0, "R3 ck_clr_o");
  end

  task automatic summary();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 150000 && !finished) begin
    n_bad++;
    $display("FAIL watchdog expired cyc=%0d", cyc);
    summary();
  end

  // mode 0 clean, 1 noisy, 2 corner (ties R6, full scale R10, middle spike R5)
  task automatic run_msg(input int mode, input int abort_at);
    int smp[$];
    int ends[NT];
    bit vals[NT];
    int n, t, acc, stop;
    acc = 0;
    for (int j = 0; j < NT; j++) begin
      int len, sa, sb;
      bit v;
      len = (j % 2) ? SE + 1 : SE;
      v = rnd(2) == 1;
      for (int p = 0; p < len; p++) begin
        int s;
        bit early;
        early = p < HF;
        if (mode == 0) s = (early == v) ? 800 + rnd(100) : 20 + rnd(30);
        else if (mode == 1) s = rnd(4096);
        else begin
          case (j % 4)
            0: s = 500;
            1: s = early ? 4095 : 4094;
            2: s = early ? 100 : 101;
            default: s = early ? 200 : 201;
          endcase
        end
        if (len == SE + 1 && p == HF) s = (mode == 2) ? 4095 : rnd(4096);
        smp.push_back(s);
      end
      sa = 0; sb = 0;
      for (int p = 0; p < HF; p++) sa += smp[acc + p];
      for (int p = len - HF; p < len; p++) sb += smp[acc + p];
      acc += len;
      ends[j] = acc;
      vals[j] = sa > sb;
    end
    @(negedge clk);
    n = cyc;
    t = n + 2;
    e_clr[t] = 1'b1;
    for (int j = 0; j < NT; j++)
      if (abort_at < 0 || ends[j] <= abort_at) begin
        e_vld[t + ends[j]] = 1'b1;
        e_bit[t + ends[j]] = vals[j];
        e_ck[t + ends[j]] = (j >= ND);
        e_done[t + ends[j]] = (j == NT - 1);
      end
    stop = (abort_at < 0) ? t + ends[NT-1] - 1 : t + abort_at;
    for (int c = t; c <= stop; c++) begin
      if (c < t + ends[ND-1]) e_dp[c] = 1'b1;
      else e_cp[c] = 1'b1;
    end
    sync = 1'b1;
    @(negedge clk); sync = 1'b0; t0 = 1'b1;
    for (int k = 0; k < smp.size(); k++) begin
      @(negedge clk);
      t0 = 1'b0;
      mag = MW'(smp[k]);
      abort = (k == abort_at);
    end
    @(negedge clk); mag = '0; abort = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(bit_vld_o | bit_o | bit_is_ck_o | msg_done_o | ck_clr_o, 1'b0, "R1 outputs in reset");
    chk(data_phase_o | ck_phase_o, 1'b0, "R1 phases in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    chk(data_phase_o | ck_phase_o | bit_vld_o, 1'b0, "R1 idle after reset");
    mon_en = 1'b1;

    // R2 t0 alone in search is ignored
    t0 = 1'b1; @(negedge clk); t0 = 1'b0;
    repeat (3) @(negedge clk);
    chk(data_phase_o, 1'b0, "R2 t0 ignored in search");
    // R2 waiting without t0
    sync = 1'b1; @(negedge clk); sync = 1'b0;
    repeat (30) @(negedge clk);
    chk(data_phase_o | ck_phase_o, 1'b0, "R2 wait holds without t0");
    // R9 abort while waiting, then t0 ignored
    abort = 1'b1; @(negedge clk); abort = 1'b0; t0 = 1'b1; @(negedge clk); t0 = 1'b0;
    repeat (3) @(negedge clk);
    chk(data_phase_o, 1'b0, "R9 t0 after abort ignored");

    ctx = "R6 clean"; run_msg(0, -1);
    ctx = "R6 noisy"; run_msg(1, -1);
    ctx = "R5 R6 R10 corner"; run_msg(2, -1);
    ctx = "R9 abort on last sample of bit 20"; run_msg(0, 261);
    ctx = "R9 abort in checksum phase"; run_msg(1, 1300);
    ctx = "R9 recovery"; run_msg(0, -1);

    summary();
  end
endmodule